// File: doc/BRIEF.md
# Multi-Mode DRAM Burst Read Sequencer

This block produces the cycle-by-cycle control of a four-beat burst read from page-oriented main memory. A requester presents a start pulse together with a full word address and a memory-type select. The sequencer opens the addressed row, walks through four column accesses in that row, and marks each cycle in which a data element can be taken with a valid strobe. One engine covers four memory behaviours: fast-page, extended-data-out, burst extended-data-out and synchronous DRAM. Each has its own lead-off count, per-beat spacing, strobe shape and column addressing rule.

The address splits into a row field in the upper bits and a column field in the lower bits. The select is captured only when a burst is accepted. Further start requests are ignored until the burst has retired with its done pulse. The outputs are the row and column strobes, the output-enable, the row and column addresses, the beat index, and the valid, busy and done flags. Cycle numbering below counts the first cycle after the accepting clock edge as cycle 1.

The controller is a Moore state machine with the states IDLE, ROW (row activation), LEAD (first column lead-off), BEAT (data cycle), GAP (wait between beats) and DONE. The transitions are: IDLE to ROW on an accepted start; ROW to LEAD once the activation cycles have elapsed; LEAD to BEAT at the end of the lead-off; BEAT to BEAT when beats are back to back; BEAT to GAP when the mode spaces beats apart; GAP to BEAT when the spacing has elapsed; BEAT to DONE after the fourth beat; and DONE to IDLE unconditionally.

Top module: `dram_burst_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, busy_o, done_o, valid_o, ras_o, cas_o and oe_o are all low.
- R2: A start_i seen high in an idle cycle is accepted and captures mode_i (0 = fast-page, 1 = extended-data-out, 2 = burst-EDO, 3 = synchronous) and addr_i, with the row in the upper ROW_W bits and the column in the lower COL_W bits. busy_o is high from cycle 1 through the done cycle and low afterwards. A start_i arriving while busy_o is high, including in the done cycle, is ignored, as is any change of mode_i.
- R3: Cycles 1 and 2 activate the row: ras_o is high, cas_o is low, and row_o shows the captured row field.
- R4: In fast-page mode the beats fall in cycles 6, 9, 12 and 15. oe_o is high only in beat cycles. In the first cycle after each of the first three beats cas_o is low, and in the second cycle it is high again.
- R5: In extended-data-out mode the beats fall in cycles 6, 8, 10 and 12. oe_o stays high from cycle 6 through cycle 12, and cas_o is low in the single cycle between beats.
- R6: In burst-EDO and synchronous modes the beats fall in cycles 5, 6, 7 and 8, and cas_o is high from cycle 3 through cycle 8.
- R7: In synchronous mode ras_o is high in cycle 1 only. In the other modes ras_o stays high from cycle 1 through the last beat cycle.
- R8: In fast-page and extended-data-out modes, the column for beat k is (first column + k) modulo 2^COL_W.
- R9: In burst-EDO and synchronous modes, the column for beat k comes from an internal counter. Its upper bits equal those of the first column, and its two low bits are (first column + k) modulo 4.
- R10: beat_o reads 0, 1, 2, 3 on the four valid beats. done_o is high for exactly one cycle, the one after the fourth beat, and in that cycle valid_o, cas_o and oe_o are low.
- R11: Whenever cas_o is high from cycle 3 onward, col_o shows the column of the current beat. On a gap cycle with cas_o high it shows the column of the next beat. In every mode, valid_o implies cas_o and oe_o are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request, taken only when idle |
| mode_i | input | 2 | Memory type select |
| addr_i | input | ROW_W+COL_W | Start address, row above column |
| ras_o | output | 1 | Row strobe |
| cas_o | output | 1 | Column strobe |
| oe_o | output | 1 | Output-enable |
| row_o | output | ROW_W | Captured row address |
| col_o | output | COL_W | Column address of current access |
| beat_o | output | 2 | Beat index |
| valid_o | output | 1 | Data element available this cycle |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst retired |

## Verification
Two functions can meet in one cycle: the admission of a new request and the retirement of the running burst. During its done cycle the sequencer still reports busy, so a start that coincides with done must be refused rather than chained. The bench raises start_i with a different mode in the done cycle, in a beat cycle and early in the lead-off. It then requires busy_o to be low in each of the next two cycles, and requires the disturbed burst to match the undisturbed profile beat for beat.

// File: rtl/dram_burst_pkg.sv
package dram_burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        MODE_FPM  = 2'd0,
        MODE_EDO  = 2'd1,
        MODE_BEDO = 2'd2,
        MODE_SYNC = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_LEAD = 3'd2,
        ST_BEAT = 3'd3,
        ST_GAP  = 3'd4,
        ST_DONE = 3'd5
    } seq_state_e;

endpackage

// File: rtl/dram_burst_timing.sv
module dram_burst_timing
    import dram_burst_pkg::*;
#(
    parameter int ROW_CYC    = 2,
    parameter int LEAD_PAGE  = 6,
    parameter int LEAD_BURST = 5,
    parameter int GAP_FPM    = 3,
    parameter int GAP_EDO    = 2,
    parameter int CNT_W      = 4
) (
    input  rd_mode_e           mode,
    output logic [CNT_W-1:0]   lead_len,
    output logic [CNT_W-1:0]   gap_len,
    output logic               wrap_cols
);

    localparam int LEAD_PAGE_CYC  = LEAD_PAGE - 1 - ROW_CYC;
    localparam int LEAD_BURST_CYC = LEAD_BURST - 1 - ROW_CYC;

    always_comb begin
        unique case (mode)
            MODE_FPM: begin
                lead_len  = CNT_W'(LEAD_PAGE_CYC);
                gap_len   = CNT_W'(GAP_FPM);
                wrap_cols = 1'b0;
            end
            MODE_EDO: begin
                lead_len  = CNT_W'(LEAD_PAGE_CYC);
                gap_len   = CNT_W'(GAP_EDO);
                wrap_cols = 1'b0;
            end
            default: begin
                lead_len  = CNT_W'(LEAD_BURST_CYC);
                gap_len   = CNT_W'(1);
                wrap_cols = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dram_col_gen.sv
module dram_col_gen
    import dram_burst_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] beat,
    input  logic              wrap_cols,
    output logic [COL_W-1:0]  col
);

    logic [COL_W-1:0] linear_col;
    logic [COL_W-1:0] wrapped_col;

    assign linear_col = base_col + COL_W'(beat);

    generate
        if (COL_W > BEAT_W) begin : g_split
            logic [BEAT_W-1:0] low_cnt;
            assign low_cnt     = base_col[BEAT_W-1:0] + beat;
            assign wrapped_col = {base_col[COL_W-1:BEAT_W], low_cnt};
        end else begin : g_narrow
            assign wrapped_col = linear_col;
        end
    endgenerate

    assign col = wrap_cols ? wrapped_col : linear_col;

endmodule

// File: rtl/dram_burst_fsm.sv
module dram_burst_fsm
    import dram_burst_pkg::*;
#(
    parameter int ROW_CYC = 2,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  rd_mode_e          mode_i,
    input  logic [CNT_W-1:0]  lead_len,
    input  logic [CNT_W-1:0]  gap_len,
    output rd_mode_e          mode_q,
    output logic              accept,
    output logic              col_active,
    output logic [BEAT_W-1:0] beat_q,
    output logic              ras,
    output logic              cas,
    output logic              oe,
    output logic              valid,
    output logic              busy,
    output logic              done
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BEAT_W-1:0] beat_d;
    logic              gap_first;
    logic              row_first;

    assign accept = (state_q == ST_IDLE) && start_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            mode_q  <= MODE_FPM;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            beat_q  <= beat_d;
            if (accept) begin
                mode_q <= mode_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = '0;
                if (start_i) begin
                    state_d = ST_ROW;
                    cnt_d   = CNT_W'(ROW_CYC - 1);
                end
            end
            ST_ROW: begin
                if (cnt_q == '0) begin
                    state_d = ST_LEAD;
                    cnt_d   = lead_len - CNT_W'(1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_LEAD: begin
                if (cnt_q == '0) begin
                    state_d = ST_BEAT;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_BEAT: begin
                if (beat_q == LAST_BEAT) begin
                    state_d = ST_DONE;
                end else begin
                    beat_d = beat_q + BEAT_W'(1);
                    if (gap_len == CNT_W'(1)) begin
                        state_d = ST_BEAT;
                    end else begin
                        state_d = ST_GAP;
                        cnt_d   = gap_len - CNT_W'(2);
                    end
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) begin
                    state_d = ST_BEAT;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign gap_first = (cnt_q == (gap_len - CNT_W'(2)));
    assign row_first = (cnt_q == CNT_W'(ROW_CYC - 1));

    // outputs
    always_comb begin
        ras        = 1'b0;
        cas        = 1'b0;
        oe         = 1'b0;
        valid      = 1'b0;
        col_active = 1'b0;
        busy       = (state_q != ST_IDLE);
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ROW: begin
                ras = (mode_q == MODE_SYNC) ? row_first : 1'b1;
            end
            ST_LEAD: begin
                ras        = (mode_q != MODE_SYNC);
                cas        = 1'b1;
                col_active = 1'b1;
            end
            ST_BEAT: begin
                ras        = (mode_q != MODE_SYNC);
                cas        = 1'b1;
                oe         = 1'b1;
                valid      = 1'b1;
                col_active = 1'b1;
            end
            ST_GAP: begin
                ras        = (mode_q != MODE_SYNC);
                cas        = (mode_q == MODE_FPM) && !gap_first;
                oe         = (mode_q == MODE_EDO);
                col_active = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dram_burst_pkg::*;
#(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 6,
    parameter int ROW_CYC    = 2,
    parameter int LEAD_PAGE  = 6,
    parameter int LEAD_BURST = 5,
    parameter int GAP_FPM    = 3,
    parameter int GAP_EDO    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [1:0]             mode_i,
    input  logic [ROW_W+COL_W-1:0] addr_i,
    output logic                   ras_o,
    output logic                   cas_o,
    output logic                   oe_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_W-1:0]       col_o,
    output logic [1:0]             beat_o,
    output logic                   valid_o,
    output logic                   busy_o,
    output logic                   done_o
);

    localparam int CNT_W = $clog2(LEAD_PAGE + GAP_FPM + 1);

    rd_mode_e          mode_q;
    logic              accept;
    logic              col_active;
    logic [BEAT_W-1:0] beat_q;
    logic [CNT_W-1:0]  lead_len;
    logic [CNT_W-1:0]  gap_len;
    logic              wrap_cols;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_base_q;
    logic [COL_W-1:0]  col_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            col_base_q <= '0;
        end else if (accept) begin
            row_q      <= addr_i[ROW_W+COL_W-1:COL_W];
            col_base_q <= addr_i[COL_W-1:0];
        end
    end

    dram_burst_timing #(
        .ROW_CYC(ROW_CYC), .LEAD_PAGE(LEAD_PAGE), .LEAD_BURST(LEAD_BURST),
        .GAP_FPM(GAP_FPM), .GAP_EDO(GAP_EDO), .CNT_W(CNT_W)
    ) u_timing (
        .mode(mode_q), .lead_len(lead_len), .gap_len(gap_len), .wrap_cols(wrap_cols)
    );

    dram_col_gen #(.COL_W(COL_W)) u_col (
        .base_col(col_base_q), .beat(beat_q), .wrap_cols(wrap_cols), .col(col_cur)
    );

    dram_burst_fsm #(.ROW_CYC(ROW_CYC), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(rd_mode_e'(mode_i)),
        .lead_len(lead_len), .gap_len(gap_len), .mode_q(mode_q), .accept(accept),
        .col_active(col_active), .beat_q(beat_q), .ras(ras_o), .cas(cas_o),
        .oe(oe_o), .valid(valid_o), .busy(busy_o), .done(done_o)
    );

    assign row_o  = row_q;
    assign col_o  = col_active ? col_cur : '0;
    assign beat_o = beat_q;

endmodule

// File: rtl/dram_burst_seq_chk.sv
module dram_burst_seq_chk #(
    parameter int COL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_o,
    input logic             cas_o,
    input logic             oe_o,
    input logic [COL_W-1:0] col_o,
    input logic [1:0]       beat_o,
    input logic             valid_o,
    input logic             busy_o,
    input logic             done_o
);

    assert_row_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (ras_o && !cas_o));

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!valid_o && !cas_o && !oe_o));

    assert_beat_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cas_o && oe_o && busy_o));

    assert_col_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (col_o[1:0] == $past(col_o[1:0]) + 2'd1));

    assert_beat_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (beat_o == $past(beat_o) + 2'd1));

endmodule

bind dram_burst_seq dram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_o(ras_o), .cas_o(cas_o), .oe_o(oe_o),
    .col_o(col_o), .beat_o(beat_o), .valid_o(valid_o), .busy_o(busy_o),
    .done_o(done_o)
);

// File: tb/dram_burst_seq_bench.sv
module dram_burst_seq_bench;

    localparam int ROW_W = 8;
    localparam int COL_W = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic [1:0]             mode_i = 2'd0;
    logic [ROW_W+COL_W-1:0] addr_i = '0;
    logic                   ras_o, cas_o, oe_o, valid_o, busy_o, done_o;
    logic [ROW_W-1:0]       row_o;
    logic [COL_W-1:0]       col_o;
    logic [1:0]             beat_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dram_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .ras_o(ras_o), .cas_o(cas_o), .oe_o(oe_o),
        .row_o(row_o), .col_o(col_o), .beat_o(beat_o), .valid_o(valid_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_burst(input int m, input int row, input int col, input bit disturb);
        int lead, gap, last, k, ph;
        int exp_col, exp_ras, exp_cas, exp_oe, exp_valid;
        string rq;
        lead = (m < 2) ? 6 : 5;
        gap  = (m == 0) ? 3 : ((m == 1) ? 2 : 1);
        last = lead + 3 * gap;
        rq   = (m == 0) ? "R4" : ((m == 1) ? "R5" : "R6");
        @(negedge clk);
        start_i = 1'b1;
        mode_i  = 2'(m);
        addr_i  = {ROW_W'(row), COL_W'(col)};
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 1; n <= last + 1; n++) begin
            exp_valid = (n >= lead && n <= last && ((n - lead) % gap) == 0) ? 1 : 0;
            ph = (n >= lead) ? ((n - lead) % gap) : 0;
            k  = (n < lead) ? 0 : ((n - lead + gap - 1) / gap);
            exp_ras = (m == 3) ? ((n == 1) ? 1 : 0) : ((n <= last) ? 1 : 0);
            if (n >= 3 && n < lead) exp_cas = 1;
            else if (n >= lead && n <= last)
                exp_cas = (m == 0) ? ((ph != 1) ? 1 : 0) : ((m == 1) ? ((ph == 0) ? 1 : 0) : 1);
            else exp_cas = 0;
            exp_oe = (m == 1) ? ((n >= lead && n <= last) ? 1 : 0) : exp_valid;
            if (m < 2) exp_col = (col + k) % (1 << COL_W);
            else       exp_col = (col & ~3) | ((col + k) & 3);
            chk(rq, "valid", int'(valid_o), exp_valid);
            chk((n <= 2) ? "R3" : "R7", "ras", int'(ras_o), exp_ras);
            chk((n <= 2) ? "R3" : rq, "cas", int'(cas_o), exp_cas);
            chk(rq, "oe", int'(oe_o), exp_oe);
            chk("R2", "busy", int'(busy_o), 1);
            chk("R10", "done", int'(done_o), (n == last + 1) ? 1 : 0);
            if (n <= 2) chk("R3", "row", int'(row_o), row);
            if (exp_cas == 1 && n >= 3)
                chk((m < 2) ? "R8" : "R9", "col", int'(col_o), exp_col);
            if (exp_valid == 1) begin
                chk("R10", "beat", int'(beat_o), k);
                chk("R11", "col_on_beat", int'(col_o), exp_col);
            end
            if (disturb && (n == 3 || n == last || n == last + 1)) begin
                start_i = 1'b1;
                mode_i  = 2'(3 - m);
                addr_i  = ~addr_i;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R2", "busy_after", int'(busy_o), 0);
        @(negedge clk);
        chk("R2", "busy_idle", int'(busy_o), 0);
        chk("R1", "ras_idle", int'(ras_o), 0);
    endtask

    initial begin
        int cols[8] = '{0, 1, 2, 3, 5, 61, 62, 63};
        repeat (3) @(negedge clk);
        chk("R1", "busy_rst", int'(busy_o), 0);
        chk("R1", "valid_rst", int'(valid_o), 0);
        chk("R1", "strobes_rst", int'({ras_o, cas_o, oe_o, done_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy_after_rst", int'(busy_o), 0);
        chk("R1", "strobes_after_rst", int'({ras_o, cas_o, oe_o, done_o, valid_o}), 0);
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                run_burst(m, (m * 37 + c * 11) % 256, cols[c], 1'b0);
                run_burst(m, (m * 5 + c * 29 + 3) % 256, cols[c], 1'b1);
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule